// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block decides which interrupt request a small 8-bit processor core should take next. It watches five request lines. The first is a non-maskable line that needs both a rising edge and a sustained high level. The second is a maskable line caught by a rising-edge latch. The third and fourth are maskable level lines. The fifth is a general level line that depends only on the global enable. The block owns the edge latches, the three per-line mask bits and the global enable flip-flop. It accepts enable, disable and set-mask commands from the core.

When the core strobes an instruction boundary, the block picks the highest-priority request that is allowed to run. It holds the winner, with its source code and vector address, until the core acknowledges it. The acknowledge clears the matching edge latch and the global enable, so a service routine runs with interrupts off until it re-enables them.

For the general line, the block raises an external-opcode flag and gives no vector. A status port shows the mask bits, the global enable and the three maskable pending signals.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, no grant is reported. `irq_status` reads 7'b0000111 when the request lines are low: all masks set and the global enable clear.
- R2: At a boundary, the winner is chosen in this fixed order: non-maskable (source 0), edge line (source 1), level line A (source 2), level line B (source 3), general line (source 4).
- R3: The non-maskable line is granted only if its rising-edge latch was set on an earlier clock and the line is still high at the boundary. Masks and the global enable do not affect it.
- R4: After a non-maskable grant is acknowledged, a line that stays high is not granted again until it goes low and then high.
- R5: The edge line's latch holds a request after the line falls. The latch is cleared by acknowledging a source-1 grant, or by a set-mask command with operand bit 4 high. It is shown in status bit 6.
- R6: Level lines A and B have no latch. A level that drops before the boundary is not granted. Their live levels are shown in status bits 5 (A) and 4 (B).
- R7: A maskable line is granted only when it is pending, its mask bit is 0 and the global enable is 1.
- R8: The vector output is 0x0024 for source 0, 0x003C for source 1, 0x0034 for source 2 and 0x002C for source 3. For source 4, `irq_ext` is 1 and the vector is 0.
- R9: An enable command sets the global enable (status bit 3) and a disable command clears it. Any acknowledge of a grant clears it, and an acknowledge or disable overrides an enable in the same cycle.
- R10: A set-mask command loads masks from operand bits [2:0] (bit 0 line B, bit 1 line A, bit 2 edge line) only when operand bit 3 is 1. The general line ignores the masks.
- R11: A grant is decided only on a boundary strobe. It is held with a stable source until acknowledged, and boundaries seen while a grant is held are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| nmi_in | input | 1 | Non-maskable request line |
| edge_in | input | 1 | Rising-edge maskable request line |
| lvl_a_in | input | 1 | Level maskable request line A |
| lvl_b_in | input | 1 | Level maskable request line B |
| gen_in | input | 1 | General level request line |
| en_cmd | input | 1 | Set global enable |
| dis_cmd | input | 1 | Clear global enable |
| mask_cmd | input | 1 | Set-mask command strobe |
| mask_d | input | 5 | Set-mask operand |
| boundary | input | 1 | Instruction-boundary strobe |
| ack | input | 1 | Core acknowledges the held grant |
| irq_valid | output | 1 | Grant held |
| irq_src | output | 3 | Source code of the held grant |
| irq_vec | output | VW | Vector address of the held grant |
| irq_ext | output | 1 | General line granted; opcode comes from outside |
| irq_status | output | 7 | {edge latch, level A, level B, enable, masks[2:0]} |

## Verification
On every cycle, the assertions check the following. A grant appears only after a boundary and holds steady until acknowledged. An acknowledge always drops the global enable. A non-maskable grant required the line to be high at its boundary. A maskable grant required the enable. A source-1 grant required the latch. A set-mask command without its enable bit leaves the masks unchanged.

Only the directed scenarios can show the rest. These are the full priority order with all lines active, the exact vectors, and the edge-then-level behaviour of the non-maskable line, including re-arming after a low-high cycle. They also cover the software clear of the edge latch, a level dropping before the boundary, and the general line ignoring the masks.

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int VW = 16,
  parameter logic [VW-1:0] TRAP_VEC = 'h0024,
  parameter logic [VW-1:0] E_VEC    = 'h003C,
  parameter logic [VW-1:0] A_VEC    = 'h0034,
  parameter logic [VW-1:0] B_VEC    = 'h002C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nmi_in,
  input  logic          edge_in,
  input  logic          lvl_a_in,
  input  logic          lvl_b_in,
  input  logic          gen_in,
  input  logic          en_cmd,
  input  logic          dis_cmd,
  input  logic          mask_cmd,
  input  logic [4:0]    mask_d,
  input  logic          boundary,
  input  logic          ack,
  output logic          irq_valid,
  output logic [2:0]    irq_src,
  output logic [VW-1:0] irq_vec,
  output logic          irq_ext,
  output logic [6:0]    irq_status
);
  localparam logic [2:0] S_NMI = 3'd0, S_EDGE = 3'd1, S_A = 3'd2, S_B = 3'd3, S_GEN = 3'd4;

  logic       nmi_q, edge_q, nmi_lat, edge_lat, ie, valid_q;
  logic [2:0] mask, src_q, win_src;
  logic       win;

  wire nmi_rise  = nmi_in & ~nmi_q;
  wire edge_rise = edge_in & ~edge_q;
  wire ack_hit   = valid_q & ack;
  wire clr_nmi   = ack_hit & (src_q == S_NMI);
  wire clr_edge  = (ack_hit & (src_q == S_EDGE)) | (mask_cmd & mask_d[4]);

  wire go_nmi  = nmi_lat & nmi_in;
  wire go_edge = edge_lat & ~mask[2] & ie;
  wire go_a    = lvl_a_in & ~mask[1] & ie;
  wire go_b    = lvl_b_in & ~mask[0] & ie;
  wire go_gen  = gen_in & ie;

  always_comb begin
    win = 1'b1;
    if (go_nmi)       win_src = S_NMI;
    else if (go_edge) win_src = S_EDGE;
    else if (go_a)    win_src = S_A;
    else if (go_b)    win_src = S_B;
    else if (go_gen)  win_src = S_GEN;
    else begin
      win     = 1'b0;
      win_src = S_NMI;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q    <= 1'b0;
      edge_q   <= 1'b0;
      nmi_lat  <= 1'b0;
      edge_lat <= 1'b0;
      ie       <= 1'b0;
      mask     <= 3'b111;
      valid_q  <= 1'b0;
      src_q    <= S_NMI;
    end else begin
      nmi_q  <= nmi_in;
      edge_q <= edge_in;

      if (nmi_rise)     nmi_lat <= 1'b1;
      else if (clr_nmi) nmi_lat <= 1'b0;

      if (edge_rise)     edge_lat <= 1'b1;
      else if (clr_edge) edge_lat <= 1'b0;

      if (ack_hit || dis_cmd) ie <= 1'b0;
      else if (en_cmd)        ie <= 1'b1;

      if (mask_cmd && mask_d[3]) mask <= mask_d[2:0];

      if (ack_hit) valid_q <= 1'b0;
      else if (!valid_q && boundary && win) begin
        valid_q <= 1'b1;
        src_q   <= win_src;
      end
    end
  end

  always_comb begin
    case (src_q)
      S_NMI:   irq_vec = TRAP_VEC;
      S_EDGE:  irq_vec = E_VEC;
      S_A:     irq_vec = A_VEC;
      S_B:     irq_vec = B_VEC;
      default: irq_vec = '0;
    endcase
    if (!valid_q) irq_vec = '0;
  end

  assign irq_valid  = valid_q;
  assign irq_src    = src_q;
  assign irq_ext    = valid_q & (src_q == S_GEN);
  assign irq_status = {edge_lat, lvl_a_in, lvl_b_in, ie, mask};
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       nmi_in,
  input logic       boundary,
  input logic       ack,
  input logic       mask_cmd,
  input logic       msk_en,
  input logic       valid,
  input logic [2:0] src,
  input logic       st_edge,
  input logic       st_ie,
  input logic [2:0] st_mask
);
  assert_hold_until_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ack |=> valid && $stable(src));
  assert_grant_after_boundary_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(boundary));
  assert_ack_drops_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid && ack |=> !st_ie && !valid);
  assert_nmi_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) && src == 3'd0 |-> $past(nmi_in));
  assert_maskable_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) && src != 3'd0 |-> $past(st_ie));
  assert_edge_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) && src == 3'd1 |-> $past(st_edge));
  assert_mask_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mask_cmd && !msk_en |=> $stable(st_mask));
endmodule

bind irq_arbiter irq_arbiter_chk chk_i (
  .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .boundary(boundary), .ack(ack),
  .mask_cmd(mask_cmd), .msk_en(mask_d[3]), .valid(irq_valid), .src(irq_src),
  .st_edge(irq_status[6]), .st_ie(irq_status[3]), .st_mask(irq_status[2:0])
);

// File: tb/irq_arbiter_tb.sv
module irq_arbiter_tb_top;
  logic clk = 0, rst_n = 0;
  logic nmi_in = 0, edge_in = 0, lvl_a_in = 0, lvl_b_in = 0, gen_in = 0;
  logic en_cmd = 0, dis_cmd = 0, mask_cmd = 0, boundary = 0, ack = 0;
  logic [4:0] mask_d = 0;
  logic irq_valid, irq_ext;
  logic [2:0] irq_src;
  logic [15:0] irq_vec;
  logic [6:0] irq_status;
  int nvec = 0, nbad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_arbiter dut_i (.*);

  task automatic step(); @(negedge clk); endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic enable();  en_cmd = 1; step(); en_cmd = 0; endtask
  task automatic disable_i(); dis_cmd = 1; step(); dis_cmd = 0; endtask
  task automatic setmask(logic [4:0] d); mask_cmd = 1; mask_d = d; step(); mask_cmd = 0; mask_d = 0; endtask
  task automatic bnd(); boundary = 1; step(); boundary = 0; endtask
  task automatic do_ack(); ack = 1; step(); ack = 0; endtask

  task automatic expect_grant(string tag, logic [2:0] s, logic [15:0] v, logic e);
    bnd();
    chk({tag, " valid"}, irq_valid, 1);
    chk({tag, " src"}, irq_src, s);
    chk({tag, " vec"}, irq_vec, v);
    chk({tag, " ext"}, irq_ext, e);
    do_ack();
    chk({tag, " R9 ack clears enable"}, irq_status[3], 0);
    chk({tag, " ack drops valid"}, irq_valid, 0);
  endtask

  task automatic expect_none(string tag);
    bnd();
    chk(tag, irq_valid, 0);
  endtask

  task automatic t_reset();
    chk("R1 valid", irq_valid, 0);
    chk("R1 status", irq_status, 7'b0000111);
  endtask

  task automatic t_gate();
    lvl_a_in = 1; step();
    expect_none("R7 enable off");
    enable();
    expect_none("R7 masked");
    setmask(5'b00000);
    chk("R10 no load without bit3", irq_status[2:0], 3'b111);
    setmask(5'b01000);
    chk("R10 load", irq_status[2:0], 3'b000);
    expect_grant("R8 line A", 3'd2, 16'h0034, 0);
    lvl_a_in = 0; step();
  endtask

  task automatic t_enable();
    enable();
    chk("R9 enable", irq_status[3], 1);
    disable_i();
    chk("R9 disable", irq_status[3], 0);
    en_cmd = 1; dis_cmd = 1; step(); en_cmd = 0; dis_cmd = 0;
    chk("R9 disable wins", irq_status[3], 0);
    gen_in = 1; step();
    expect_none("R9 general blocked when disabled");
    gen_in = 0; step();
  endtask

  task automatic t_level_drop();
    enable();
    lvl_b_in = 1; step();
    chk("R6 status B live", irq_status[4], 1);
    lvl_b_in = 0; step();
    expect_none("R6 level dropped");
    disable_i();
  endtask

  task automatic t_priority();
    edge_in = 1; lvl_a_in = 1; lvl_b_in = 1; gen_in = 1; step();
    enable();
    expect_grant("R2 edge first", 3'd1, 16'h003C, 0);
    chk("R5 ack clears latch", irq_status[6], 0);
    enable();
    expect_grant("R2 A next", 3'd2, 16'h0034, 0);
    lvl_a_in = 0; enable();
    expect_grant("R2 B next", 3'd3, 16'h002C, 0);
    lvl_b_in = 0; enable();
    expect_grant("R2 general last", 3'd4, 16'h0000, 1);
    gen_in = 0; edge_in = 0; step();
  endtask

  task automatic t_general_masks();
    setmask(5'b01111);
    gen_in = 1; enable();
    expect_grant("R10 general ignores masks", 3'd4, 16'h0000, 1);
    gen_in = 0; step();
  endtask

  task automatic t_hold();
    gen_in = 1; enable();
    repeat (3) step();
    chk("R11 no boundary no grant", irq_valid, 0);
    bnd();
    chk("R11 granted general", irq_src, 3'd4);
    lvl_a_in = 1; setmask(5'b01000); bnd();
    chk("R11 held across boundary", irq_src, 3'd4);
    chk("R11 still valid", irq_valid, 1);
    do_ack();
    gen_in = 0; lvl_a_in = 0; step();
  endtask

  task automatic t_edge_latch();
    setmask(5'b01000);
    edge_in = 1; step(); edge_in = 0; step();
    chk("R5 latch holds", irq_status[6], 1);
    enable();
    expect_grant("R5 latched grant", 3'd1, 16'h003C, 0);
    edge_in = 1; step(); edge_in = 0; step();
    setmask(5'b01100);
    enable();
    expect_none("R7 edge masked");
    chk("R5 masked still pending", irq_status[6], 1);
    setmask(5'b10000);
    chk("R5 software clear", irq_status[6], 0);
    chk("R10 bit4 alone keeps masks", irq_status[2:0], 3'b100);
    setmask(5'b01000);
    expect_none("R5 cleared not granted");
    disable_i();
  endtask

  task automatic t_nmi();
    setmask(5'b01111);
    nmi_in = 1; step();
    expect_grant("R3 nmi ignores enable/mask", 3'd0, 16'h0024, 0);
    expect_none("R4 held high not re-recognized");
    nmi_in = 0; step(); nmi_in = 1; step();
    expect_grant("R4 re-armed", 3'd0, 16'h0024, 0);
    nmi_in = 0; step(); nmi_in = 1; step(); nmi_in = 0; step();
    expect_none("R3 edge without level");
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    t_reset();
    t_gate();
    t_enable();
    t_level_drop();
    t_priority();
    t_general_masks();
    t_hold();
    t_edge_latch();
    t_nmi();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nvec++; nbad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule